// File: doc/BRIEF.md
# Single-Channel DMA Engine

This block copies a run of words from one region of the address space to another so that the processor does not have to move them itself. Software sets up a source start address, a destination start address, a word count and a block size, picks one of two bus-sharing policies, and then sets a start bit. The engine asks for the system bus with a request line and does nothing on the bus until an arbiter answers with a grant. Each word goes over as a read from the current source address and then a write to the current destination address, and both addresses step up by one after every word.

In cycle-steal mode the engine keeps its request up and uses only the cycles in which the processor reports that it is not on the bus. In burst mode the engine holds the bus for one whole block and moves it in back-to-back cycles. It then lets go of the request for one cycle before it asks again for the next block. A sticky done flag, which can also serve as an interrupt line, rises once the last word has been written.

Top module: `dma_engine`

## Requirements
- R1: After reset, `bus_req_o`, `bus_rd_o`, `bus_wr_o` and `done_o` are all low.
- R2: A read or write strobe is driven only in a cycle where both `bus_req_o` and `bus_gnt_i` are high.
- R3: Word i of a transfer is read from source start + i and then written to destination start + i. Each cycle carries a read or a write, never both. Word order rises from i = 0.
- R4: In cycle-steal mode (control bit 1 = 0), no read or write is issued in a cycle where `cpu_busy_i` is high.
- R5: In burst mode (control bit 1 = 1), a read or write happens in every cycle in which the request and the grant are both high, whatever the value of `cpu_busy_i`.
- R6: In burst mode the request is asserted once per block, which makes ceil(total / block) assertions. The request drops for at least one cycle between two blocks. A block size of 0 is treated as 1. A block size larger than the total gives a single assertion.
- R7: `done_o` rises after the final write and stays high until a control write (offset 4) sets bit 2 (clear) or bit 0 (start).
- R8: A start with a total length of 0 sets `done_o` within three cycles and never raises `bus_req_o`.
- R9: A start written while a transfer is in progress is ignored. The running transfer moves exactly its original word count.
- R10: Register offsets on `cfg_addr_i`: 0 is source start, 1 is destination start, 2 is total words, 3 is block words, and 4 is control (bit 0 start, bit 1 burst, bit 2 clear done). The engine takes a copy of the settings when it starts, so a later write to offsets 0 to 3 does not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register offset |
| cfg_wdata_i | input | DW | Register write data |
| done_o | output | 1 | Sticky completion flag / interrupt |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| cpu_busy_i | input | 1 | Processor is using the bus this cycle |
| bus_addr_o | output | AW | Bus address |
| bus_rd_o | output | 1 | Read strobe, data sampled from bus_rdata_i at the same edge |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data |

## Verification
The copy is run in steal mode with three bus-load patterns. In the first the processor never uses the bus, in the second it uses every other cycle, and in the third its use follows a pseudo-random sequence. The first shows the basic copy order. The other two show that the engine really waits for free cycles and does not simply run at a fixed rate. Burst runs use block sizes that divide the total, that leave a short last block, that are zero, and that exceed the total. From these the bench can tell the per-block request count apart from an off-by-one in the block counter. Zero-length starts, repeated starts during a run, and done-flag clearing cover the control corners.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    localparam logic [2:0] OFS_SRC  = 3'd0;
    localparam logic [2:0] OFS_DST  = 3'd1;
    localparam logic [2:0] OFS_LEN  = 3'd2;
    localparam logic [2:0] OFS_BLK  = 3'd3;
    localparam logic [2:0] OFS_CTRL = 3'd4;

    localparam int CTRL_START = 0;
    localparam int CTRL_BURST = 1;
    localparam int CTRL_CLEAR = 2;
endpackage

// File: rtl/dma_cfg.sv
module dma_cfg
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_wr_i,
    input  logic [2:0]    cfg_addr_i,
    input  logic [DW-1:0] cfg_wdata_i,
    input  logic          busy_i,
    input  logic          fin_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [LW-1:0] len_o,
    output logic [LW-1:0] blk_o,
    output logic          burst_o,
    output logic          start_o,
    output logic          done_o
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [LW-1:0] blk;
        logic          burst;
        logic          done;
    } cfg_t;

    cfg_t c_d, c_q;
    logic ctrl_wr;

    always_comb begin
        c_d     = c_q;
        ctrl_wr = cfg_wr_i && (cfg_addr_i == OFS_CTRL);
        start_o = ctrl_wr && cfg_wdata_i[CTRL_START] && !busy_i;
        if (cfg_wr_i) begin
            unique case (cfg_addr_i)
                OFS_SRC: c_d.src = cfg_wdata_i[AW-1:0];
                OFS_DST: c_d.dst = cfg_wdata_i[AW-1:0];
                OFS_LEN: c_d.len = cfg_wdata_i[LW-1:0];
                OFS_BLK: c_d.blk = cfg_wdata_i[LW-1:0];
                default: ;
            endcase
        end
        if (start_o) begin
            c_d.burst = cfg_wdata_i[CTRL_BURST];
        end
        if (ctrl_wr && (cfg_wdata_i[CTRL_CLEAR] || start_o)) begin
            c_d.done = 1'b0;
        end
        if (fin_i) begin
            c_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign src_o   = c_q.src;
    assign dst_o   = c_q.dst;
    assign len_o   = c_q.len;
    assign blk_o   = c_q.blk;
    assign burst_o = cfg_wdata_i[CTRL_BURST];
    assign done_o  = c_q.done;
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          burst_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [LW-1:0] len_i,
    input  logic [LW-1:0] blk_i,
    input  logic          bus_gnt_i,
    input  logic          cpu_busy_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          busy_o,
    output logic          fin_o,
    output logic          mode_burst_o,
    output logic          bus_req_o,
    output logic          bus_rd_o,
    output logic          bus_wr_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o
);
    localparam logic [LW-1:0] ONE = LW'(1);

    typedef struct packed {
        phase_e        phase;
        logic          burst;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] remain;
        logic [LW-1:0] blk_left;
        logic [LW-1:0] blk_len;
        logic [DW-1:0] data;
        logic          fin;
    } xfer_t;

    xfer_t s_d, s_q;
    logic  slot_ok;
    logic [LW-1:0] blk_eff;

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        blk_eff = (blk_i == '0) ? ONE : blk_i;
        slot_ok = bus_gnt_i && (s_q.burst || !cpu_busy_i);

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (len_i == '0) begin
                        s_d.fin = 1'b1;
                    end else begin
                        s_d.phase    = PH_RD;
                        s_d.burst    = burst_i;
                        s_d.src      = src_i;
                        s_d.dst      = dst_i;
                        s_d.remain   = len_i;
                        s_d.blk_len  = blk_eff;
                        s_d.blk_left = blk_eff;
                    end
                end
            end
            PH_RD: begin
                if (slot_ok) begin
                    s_d.data  = bus_rdata_i;
                    s_d.phase = PH_WR;
                end
            end
            PH_WR: begin
                if (slot_ok) begin
                    s_d.src      = s_q.src + AW'(1);
                    s_d.dst      = s_q.dst + AW'(1);
                    s_d.remain   = s_q.remain - ONE;
                    s_d.blk_left = s_q.blk_left - ONE;
                    if (s_q.remain == ONE) begin
                        s_d.phase = PH_IDLE;
                        s_d.fin   = 1'b1;
                    end else if (s_q.burst && s_q.blk_left == ONE) begin
                        s_d.phase    = PH_GAP;
                        s_d.blk_left = s_q.blk_len;
                    end else begin
                        s_d.phase = PH_RD;
                    end
                end
            end
            PH_GAP: s_d.phase = PH_RD;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{phase: PH_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign busy_o       = (s_q.phase != PH_IDLE);
    assign fin_o        = s_q.fin;
    assign mode_burst_o = s_q.burst;
    assign bus_req_o    = (s_q.phase == PH_RD) || (s_q.phase == PH_WR);
    assign bus_rd_o     = (s_q.phase == PH_RD) && slot_ok;
    assign bus_wr_o     = (s_q.phase == PH_WR) && slot_ok;
    assign bus_addr_o   = (s_q.phase == PH_WR) ? s_q.dst : s_q.src;
    assign bus_wdata_o  = s_q.data;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_wr_i,
    input  logic [2:0]    cfg_addr_i,
    input  logic [DW-1:0] cfg_wdata_i,
    output logic          done_o,
    output logic          bus_req_o,
    input  logic          bus_gnt_i,
    input  logic          cpu_busy_i,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_rd_o,
    output logic          bus_wr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i
);
    logic [AW-1:0] src, dst;
    logic [LW-1:0] len, blk;
    logic          burst_sel, start, busy, fin, mode_burst;

    dma_cfg #(.AW(AW), .LW(LW), .DW(DW)) i_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_addr_i (cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i),
        .busy_i     (busy),
        .fin_i      (fin),
        .src_o      (src),
        .dst_o      (dst),
        .len_o      (len),
        .blk_o      (blk),
        .burst_o    (burst_sel),
        .start_o    (start),
        .done_o     (done_o)
    );

    dma_xfer #(.AW(AW), .LW(LW), .DW(DW)) i_xfer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .burst_i     (burst_sel),
        .src_i       (src),
        .dst_i       (dst),
        .len_i       (len),
        .blk_i       (blk),
        .bus_gnt_i   (bus_gnt_i),
        .cpu_busy_i  (cpu_busy_i),
        .bus_rdata_i (bus_rdata_i),
        .busy_o      (busy),
        .fin_o       (fin),
        .mode_burst_o(mode_burst),
        .bus_req_o   (bus_req_o),
        .bus_rd_o    (bus_rd_o),
        .bus_wr_o    (bus_wr_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o)
    );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_i,
    input logic       gnt_i,
    input logic       rd_i,
    input logic       wr_i,
    input logic       cpu_busy_i,
    input logic       burst_i,
    input logic       done_i,
    input logic       cfg_wr_i,
    input logic [2:0] cfg_addr_i,
    input logic [2:0] ctrl_bits_i
);
    logic clr;
    assign clr = cfg_wr_i && (cfg_addr_i == 3'd4) && (ctrl_bits_i[2] || ctrl_bits_i[0]);

    AST_ACCESS_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i || wr_i) |-> (gnt_i && req_i)); // R2

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_i && wr_i)); // R3

    AST_STEAL_YIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rd_i || wr_i) && !burst_i) |-> !cpu_busy_i); // R4

    AST_BURST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_i && req_i && gnt_i) |-> (rd_i || wr_i)); // R5

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !clr) |=> done_i); // R7
endmodule

bind dma_engine dma_engine_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req_o),
    .gnt_i      (bus_gnt_i),
    .rd_i       (bus_rd_o),
    .wr_i       (bus_wr_o),
    .cpu_busy_i (cpu_busy_i),
    .burst_i    (mode_burst),
    .done_i     (done_o),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_addr_i (cfg_addr_i),
    .ctrl_bits_i(cfg_wdata_i[2:0])
);

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          done, req, rd, wr;
    logic          gnt = 1'b0;
    logic          cpu_busy = 1'b0;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dma_engine #(.AW(AW), .LW(LW), .DW(DW)) i_dma_engine (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .done_o(done), .bus_req_o(req), .bus_gnt_i(gnt),
        .cpu_busy_i(cpu_busy), .bus_addr_o(addr), .bus_rd_o(rd), .bus_wr_o(wr),
        .bus_wdata_o(wdata), .bus_rdata_i(rdata)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 16'hC0DE, a};
    endfunction

    assign rdata = pat(addr);

    // bench bus model: destination memory, arbiter, processor load
    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] last_wr_addr;
    int  busy_mode = 0;
    logic [7:0] lfsr = 8'hA7;
    logic req_prev = 1'b0;
    int n_rd = 0, n_wr = 0, n_rise = 0, n_req_cyc = 0;
    int n_busy_acc = 0, n_idle_gnt = 0, n_nogrant_acc = 0, n_both = 0;

    always @(posedge clk) begin
        gnt      <= req;
        req_prev <= req;
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (busy_mode)
            1: cpu_busy <= ~cpu_busy;
            2: cpu_busy <= lfsr[0];
            default: cpu_busy <= 1'b0;
        endcase
        if (wr) begin
            mem[addr[7:0]] <= wdata;
            last_wr_addr   <= addr;
        end
        if (rd) n_rd <= n_rd + 1;
        if (wr) n_wr <= n_wr + 1;
        if (rd && wr) n_both <= n_both + 1;
        if (req && !req_prev) n_rise <= n_rise + 1;
        if (req) n_req_cyc <= n_req_cyc + 1;
        if ((rd || wr) && cpu_busy) n_busy_acc <= n_busy_acc + 1;
        if ((rd || wr) && !(gnt && req)) n_nogrant_acc <= n_nogrant_acc + 1;
        if (req && gnt && !(rd || wr)) n_idle_gnt <= n_idle_gnt + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(done === 1'b1, tag, int'(done), 1);
    endtask

    task automatic check_copy(input int src, input int dst, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (mem[8'(dst + i)] !== pat(AW'(src + i))) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    // one transfer with given settings; ctrl bit1 = burst
    task automatic run(input int src, input int dst, input int len, input int blk,
                       input bit burst, input string tag);
        reg_wr(3'd4, 32'd4);
        reg_wr(3'd0, DW'(src));
        reg_wr(3'd1, DW'(dst));
        reg_wr(3'd2, DW'(len));
        reg_wr(3'd3, DW'(blk));
        reg_wr(3'd4, {29'd0, 1'b0, burst, 1'b1});
        wait_done(tag);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check(req == 1'b0 && rd == 1'b0 && wr == 1'b0, "R1 bus idle", int'({req, rd, wr}), 0);
        check(done == 1'b0, "R1 done low", int'(done), 0);
    endtask

    task automatic t_steal(input int mode, input int len, input int dst, input string tag);
        int r0 = n_rd, w0 = n_wr, b0 = n_busy_acc, g0 = n_nogrant_acc, x0 = n_both;
        busy_mode = mode;
        run(16, dst, len, 2, 1'b0, {tag, " R7 done"});
        check(n_busy_acc == b0, {tag, " R4 access while cpu busy"}, n_busy_acc - b0, 0);
        check(n_nogrant_acc == g0, {tag, " R2 access without grant"}, n_nogrant_acc - g0, 0);
        check(n_rd - r0 == len && n_wr - w0 == len && n_both == x0,
              {tag, " R3 word count"}, n_wr - w0, len);
        check_copy(16, dst, len, {tag, " R3 copy order"});
        check(int'(last_wr_addr) == dst + len - 1, {tag, " R3 last address"},
              int'(last_wr_addr), dst + len - 1);
        busy_mode = 0;
    endtask

    task automatic t_burst(input int len, input int blk, input int dst, input string tag);
        int i0 = n_idle_gnt, q0 = n_rise, exp_b;
        int beff = (blk == 0) ? 1 : blk;
        exp_b = (len + beff - 1) / beff;
        busy_mode = 2;
        run(40, dst, len, blk, 1'b1, {tag, " R7 done"});
        check(n_idle_gnt == i0, {tag, " R5 idle granted cycles"}, n_idle_gnt - i0, 0);
        check(n_rise - q0 == exp_b, {tag, " R6 request count"}, n_rise - q0, exp_b);
        check_copy(40, dst, len, {tag, " R3 copy"});
        busy_mode = 0;
    endtask

    task automatic t_zero;
        int q0 = n_req_cyc;
        reg_wr(3'd4, 32'd4);
        reg_wr(3'd2, 32'd0);
        reg_wr(3'd4, 32'd1);
        repeat (2) @(negedge clk);
        check(done == 1'b1, "R8 zero length done", int'(done), 1);
        check(n_req_cyc == q0, "R8 no request", n_req_cyc - q0, 0);
    endtask

    task automatic t_restart;
        int w0 = n_wr;
        busy_mode = 1;
        reg_wr(3'd4, 32'd4);
        reg_wr(3'd0, 32'd100);
        reg_wr(3'd1, 32'd200);
        reg_wr(3'd2, 32'd6);
        reg_wr(3'd4, 32'd1);
        repeat (2) @(negedge clk);
        reg_wr(3'd2, 32'd20);
        reg_wr(3'd0, 32'd7);
        reg_wr(3'd4, 32'd3);
        wait_done("R9 done");
        repeat (4) @(negedge clk);
        check(n_wr - w0 == 6, "R9 start ignored: word count", n_wr - w0, 6);
        check_copy(100, 200, 6, "R10 settings held");
        busy_mode = 0;
    endtask

    task automatic t_sticky;
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R7 done holds", int'(done), 1);
        reg_wr(3'd3, 32'd9);
        check(done == 1'b1, "R7 other write keeps done", int'(done), 1);
        reg_wr(3'd4, 32'd4);
        check(done == 1'b0, "R7 clear", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_steal(0, 5, 128, "steal free");
        t_steal(1, 7, 144, "steal alternating");
        t_steal(2, 9, 160, "steal random");
        t_burst(8, 3, 0, "burst short tail");
        t_burst(6, 2, 16, "burst even");
        t_burst(3, 0, 32, "burst blk0");
        t_burst(4, 10, 48, "burst big blk");
        t_zero();
        t_sticky();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule